// File: doc/BRIEF.md
# Reset Sequencer with Boot-Strap Latch

This block turns a handful of reset sources into three reset outputs of different reach, plus one reset per module. A power-on condition (reset pin and test-reset pin both low) clears everything, including test and emulation logic. A warm reset from the reset pin alone, or a max-reset request from a watchdog or debugger, clears everything except test logic. A debugger soft-reset request drives only a separate soft reset that leaves memories, clocks and power states alone. Software-written bits hold individual modules in reset. Every reset asserts at once, asynchronously, and is released through a two-flop synchroniser.

The same address pins that later carry bus traffic also act as configuration straps. On the first rising clock edge after a power-on, warm or max reset is removed, the block captures a boot-mode field, a memory-configuration field and an oscillator-mode bit. It then tells the pad multiplexing that the pins may go back to their bus function. From the captured boot mode it derives a boot-vector select (internal ROM or external asynchronous memory) and a vector of default module enables. This vector is used by the power controller after reset.

Top module: `boot_reset_seq`

## Requirements
- R1: While `ext_rst_n` and `tst_rst_n` are both low, `test_rst_n`, `core_rst_n` and `soft_rst_n` are all low at once. Each output goes high on the second rising edge after its own cause is removed.
- R2: `ext_rst_n` low with `tst_rst_n` high, or `max_rst_req` high, drives `core_rst_n` and `soft_rst_n` low and leaves `test_rst_n` high. Release takes two rising edges.
- R3: `sys_rst_req` high drives only `soft_rst_n` low, with release two edges after the request drops. `core_rst_n`, `test_rst_n` and the latched strap fields are not affected.
- R4: `mod_rst_n[i]` is low while `core_rst_n` is low. After that it follows the inverse of `mod_rst_bits[i]` one rising edge later. A bit has no effect on any other module.
- R5: On the first rising edge after the hard cause is removed (`ext_rst_n` high and `max_rst_req` low), `boot_mode` takes `strap_bus[13:11]`, `mem_cfg` takes `strap_bus[10:8]` and `osc_mode` takes `osc_strap`. While the hard cause is active, the three fields read 000, 000 and 0.
- R6: The captured fields hold until the next power-on, warm or max reset, whatever the pins do afterwards.
- R7: `strap_done` is 0 during a hard reset and goes to 1 at the capture edge. `core_rst_n` never rises before `strap_done` is 1.
- R8: `rom_boot` is 1 for every boot mode except 001, where it is 0 (start from external memory).
- R9: `mod_en_dflt` bits 27, 29, 30, 31, 35 and 41 (two timers, system, processor, emulation, real-time clock) are 1 in every boot mode.
- R10: Bit 14 (external-memory interface) is 1 for modes 000 and 001. Mode 010 sets bit 15 (MMC/SD), 011 sets bit 19 (UART), 100 sets bit 9 (USB), 101 sets bit 22 (SPI), 110 sets bit 40 (Ethernet) and 111 sets bit 21 (host port). All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | Board reset pin, active low |
| tst_rst_n | input | 1 | Test-reset pin, active low |
| max_rst_req | input | 1 | Watchdog/debugger max-reset request, active high |
| sys_rst_req | input | 1 | Debugger soft-reset request, active high |
| mod_rst_bits | input | 52 | Software per-module reset bits, 1 = hold in reset |
| strap_bus | input | 16 | Shared address/strap pins |
| osc_strap | input | 1 | Oscillator-mode strap pin |
| test_rst_n | output | 1 | Test/emulation logic reset, active low |
| core_rst_n | output | 1 | Core reset, active low |
| soft_rst_n | output | 1 | Memory-preserving soft reset, active low |
| boot_mode | output | 3 | Latched boot-mode field |
| mem_cfg | output | 3 | Latched memory-configuration field |
| osc_mode | output | 1 | Latched oscillator mode |
| rom_boot | output | 1 | 1 = start from internal ROM, 0 = external memory |
| mod_en_dflt | output | 52 | Default module enables after reset |
| mod_rst_n | output | 52 | Per-module reset, active low |
| strap_done | output | 1 | 1 = straps captured, pins back to bus function |

## Verification
The assertions assume that `max_rst_req` and `sys_rst_req` come from flops and are free of glitches, because they feed asynchronous reset paths. They also assume that any reset pulse spans at least one rising clock edge, so the strap hold check never sees a reset that fell entirely between two edges. The bench changes every input one time unit after a rising edge, and holds every reset for several cycles. It checks outputs at the falling edge against a behavioural model, covering all eight boot modes, separate release of the test-reset and reset pins, soft and max resets with the straps changing, and per-module reset patterns.

// File: rtl/boot_rst_pkg.sv
package boot_rst_pkg;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned NUM_MOD = 52;

  typedef enum logic [MODE_W-1:0] {
    BM_NAND_ROM = 3'd0,
    BM_XMEM     = 3'd1,
    BM_MMC_ROM  = 3'd2,
    BM_UART_ROM = 3'd3,
    BM_USB_ROM  = 3'd4,
    BM_SPI_ROM  = 3'd5,
    BM_ETH_ROM  = 3'd6,
    BM_HOST_ROM = 3'd7
  } boot_mode_e;

  // module slot numbers decoded by the power controller
  localparam int unsigned SLOT_USB   = 9;
  localparam int unsigned SLOT_XMEM  = 14;
  localparam int unsigned SLOT_MMC   = 15;
  localparam int unsigned SLOT_UART  = 19;
  localparam int unsigned SLOT_HOST  = 21;
  localparam int unsigned SLOT_SPI   = 22;
  localparam int unsigned SLOT_TMRA  = 27;
  localparam int unsigned SLOT_TMRB  = 29;
  localparam int unsigned SLOT_SYS   = 30;
  localparam int unsigned SLOT_CPU   = 31;
  localparam int unsigned SLOT_EMU   = 35;
  localparam int unsigned SLOT_ETH   = 40;
  localparam int unsigned SLOT_RTC   = 41;
endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nx;

  always_comb begin
    sh_nx = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_nx;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/brs_strap_latch.sv
module brs_strap_latch #(
  parameter int unsigned BUS_W    = 16,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned BOOT_LSB = 11,
  parameter int unsigned CFG_LSB  = 8
) (
  input  logic              clk,
  input  logic              hard_n,
  input  logic [BUS_W-1:0]  strap_bus,
  input  logic              osc_strap,
  output logic [MODE_W-1:0] boot_mode,
  output logic [MODE_W-1:0] mem_cfg,
  output logic              osc_mode,
  output logic              done
);
  logic [MODE_W-1:0] boot_q, boot_nx;
  logic [MODE_W-1:0] cfg_q, cfg_nx;
  logic              osc_q, osc_nx;
  logic              done_q, done_nx;
  logic              cap_en;
  logic              unused_pins;

  assign unused_pins = ^strap_bus;

  always_comb begin
    cap_en  = !done_q;
    boot_nx = strap_bus[BOOT_LSB +: MODE_W];
    cfg_nx  = strap_bus[CFG_LSB +: MODE_W];
    osc_nx  = osc_strap;
    done_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge hard_n) begin
    if (!hard_n) begin
      boot_q <= '0;
      cfg_q  <= '0;
      osc_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (cap_en) begin
      boot_q <= boot_nx;
      cfg_q  <= cfg_nx;
      osc_q  <= osc_nx;
      done_q <= done_nx;
    end
  end

  assign boot_mode = boot_q;
  assign mem_cfg   = cfg_q;
  assign osc_mode  = osc_q;
  assign done      = done_q;

  // R6
  straps_hold_chk: assert property (@(posedge clk) disable iff (!hard_n)
    (done_q && $past(done_q)) |-> $stable({boot_q, cfg_q, osc_q}));
endmodule

// File: rtl/brs_enable_decode.sv
module brs_enable_decode
  import boot_rst_pkg::*;
#(
  parameter int unsigned NMOD = NUM_MOD
) (
  input  logic [MODE_W-1:0] boot_mode,
  output logic              rom_boot,
  output logic [NMOD-1:0]   mod_en
);
  boot_mode_e mode;
  assign mode = boot_mode_e'(boot_mode);

  always_comb begin
    mod_en = '0;
    mod_en[SLOT_TMRA] = 1'b1;
    mod_en[SLOT_TMRB] = 1'b1;
    mod_en[SLOT_SYS]  = 1'b1;
    mod_en[SLOT_CPU]  = 1'b1;
    mod_en[SLOT_EMU]  = 1'b1;
    mod_en[SLOT_RTC]  = 1'b1;
    unique case (mode)
      BM_NAND_ROM, BM_XMEM: mod_en[SLOT_XMEM] = 1'b1;
      BM_MMC_ROM:           mod_en[SLOT_MMC]  = 1'b1;
      BM_UART_ROM:          mod_en[SLOT_UART] = 1'b1;
      BM_USB_ROM:           mod_en[SLOT_USB]  = 1'b1;
      BM_SPI_ROM:           mod_en[SLOT_SPI]  = 1'b1;
      BM_ETH_ROM:           mod_en[SLOT_ETH]  = 1'b1;
      BM_HOST_ROM:          mod_en[SLOT_HOST] = 1'b1;
      default:              mod_en[SLOT_XMEM] = 1'b1;
    endcase
    rom_boot = (mode != BM_XMEM);
  end
endmodule

// File: rtl/brs_module_reset.sv
module brs_module_reset #(
  parameter int unsigned NMOD = 52
) (
  input  logic            clk,
  input  logic            core_rst_n,
  input  logic [NMOD-1:0] sw_bits,
  output logic [NMOD-1:0] mod_rst_n
);
  logic [NMOD-1:0] hold_nx;

  always_comb begin
    hold_nx = ~sw_bits;
  end

  for (genvar i = 0; i < NMOD; i++) begin : g_mod
    logic rq;
    always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n) rq <= 1'b0;
      else             rq <= hold_nx[i];
    end
    assign mod_rst_n[i] = rq;

    // R4
    mod_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      sw_bits[i] |=> !mod_rst_n[i]);
  end
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import boot_rst_pkg::*;
#(
  parameter int unsigned NMOD     = NUM_MOD,
  parameter int unsigned BUS_W    = 16,
  parameter int unsigned BOOT_LSB = 11,
  parameter int unsigned CFG_LSB  = 8,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              tst_rst_n,
  input  logic              max_rst_req,
  input  logic              sys_rst_req,
  input  logic [NMOD-1:0]   mod_rst_bits,
  input  logic [BUS_W-1:0]  strap_bus,
  input  logic              osc_strap,
  output logic              test_rst_n,
  output logic              core_rst_n,
  output logic              soft_rst_n,
  output logic [MODE_W-1:0] boot_mode,
  output logic [MODE_W-1:0] mem_cfg,
  output logic              osc_mode,
  output logic              rom_boot,
  output logic [NMOD-1:0]   mod_en_dflt,
  output logic [NMOD-1:0]   mod_rst_n,
  output logic              strap_done
);
  localparam int unsigned NDOM = 3;
  localparam int unsigned D_TEST = 0;
  localparam int unsigned D_CORE = 1;
  localparam int unsigned D_SOFT = 2;

  logic            hard_n;
  logic [NDOM-1:0] cause_n;
  logic [NDOM-1:0] dom_rst_n;

  always_comb begin
    hard_n          = ext_rst_n & ~max_rst_req;
    cause_n[D_TEST] = ext_rst_n | tst_rst_n;
    cause_n[D_CORE] = hard_n;
    cause_n[D_SOFT] = hard_n & ~sys_rst_req;
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    brs_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk     (clk),
      .arst_n  (cause_n[d]),
      .rst_n_o (dom_rst_n[d])
    );
  end

  assign test_rst_n = dom_rst_n[D_TEST];
  assign core_rst_n = dom_rst_n[D_CORE];
  assign soft_rst_n = dom_rst_n[D_SOFT];

  brs_strap_latch #(
    .BUS_W(BUS_W), .MODE_W(MODE_W), .BOOT_LSB(BOOT_LSB), .CFG_LSB(CFG_LSB)
  ) u_strap (
    .clk       (clk),
    .hard_n    (hard_n),
    .strap_bus (strap_bus),
    .osc_strap (osc_strap),
    .boot_mode (boot_mode),
    .mem_cfg   (mem_cfg),
    .osc_mode  (osc_mode),
    .done      (strap_done)
  );

  brs_enable_decode #(.NMOD(NMOD)) u_dec (
    .boot_mode (boot_mode),
    .rom_boot  (rom_boot),
    .mod_en    (mod_en_dflt)
  );

  brs_module_reset #(.NMOD(NMOD)) u_modrst (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .sw_bits    (mod_rst_bits),
    .mod_rst_n  (mod_rst_n)
  );

  // R1
  test_in_core_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !test_rst_n |-> !core_rst_n);

  // R2
  core_in_soft_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !core_rst_n |-> !soft_rst_n);

  // R3
  soft_req_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    sys_rst_req |=> !soft_rst_n);

  // R7
  straps_first_chk: assert property (@(posedge clk) disable iff (!hard_n)
    $rose(core_rst_n) |-> strap_done);

  // R10
  one_boot_dev_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0({mod_en_dflt[SLOT_MMC], mod_en_dflt[SLOT_UART], mod_en_dflt[SLOT_USB],
              mod_en_dflt[SLOT_SPI], mod_en_dflt[SLOT_ETH], mod_en_dflt[SLOT_HOST]}));
endmodule

// File: tb/boot_reset_seq_tb_top.sv
module boot_reset_seq_tb_top;
  localparam int NM = 52;
  localparam logic [NM-1:0] AON = (52'd1 << 27) | (52'd1 << 29) | (52'd1 << 30) |
                                  (52'd1 << 31) | (52'd1 << 35) | (52'd1 << 41);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic ext_rst_n, tst_rst_n, max_rst_req, sys_rst_req, osc_strap;
  logic [NM-1:0] mod_rst_bits;
  logic [15:0] strap_bus;
  logic test_rst_n, core_rst_n, soft_rst_n, osc_mode, rom_boot, strap_done;
  logic [2:0] boot_mode, mem_cfg;
  logic [NM-1:0] mod_en_dflt, mod_rst_n;

  boot_reset_seq dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .tst_rst_n(tst_rst_n),
    .max_rst_req(max_rst_req), .sys_rst_req(sys_rst_req),
    .mod_rst_bits(mod_rst_bits), .strap_bus(strap_bus), .osc_strap(osc_strap),
    .test_rst_n(test_rst_n), .core_rst_n(core_rst_n), .soft_rst_n(soft_rst_n),
    .boot_mode(boot_mode), .mem_cfg(mem_cfg), .osc_mode(osc_mode),
    .rom_boot(rom_boot), .mod_en_dflt(mod_en_dflt), .mod_rst_n(mod_rst_n),
    .strap_done(strap_done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // behavioural model state
  int cnt_por = 0, cnt_hard = 0, cnt_soft = 0;
  bit samp = 0;
  bit [2:0] m_boot = 0, m_cfg = 0;
  bit m_osc = 0;
  bit [NM-1:0] m_mod = '0;

  function automatic logic [NM-1:0] exp_en(input bit [2:0] m);
    logic [NM-1:0] e = AON;
    case (m)
      3'd0, 3'd1: e[14] = 1'b1;
      3'd2: e[15] = 1'b1;
      3'd3: e[19] = 1'b1;
      3'd4: e[9]  = 1'b1;
      3'd5: e[22] = 1'b1;
      3'd6: e[40] = 1'b1;
      default: e[21] = 1'b1;
    endcase
    return e;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit c_por, c_hard, c_soft, e_test, e_core, e_soft, e_done;
    bit [2:0] eb;
    c_por  = !ext_rst_n && !tst_rst_n;
    c_hard = !ext_rst_n || max_rst_req;
    c_soft = c_hard || sys_rst_req;
    e_test = !c_por  && cnt_por  >= 2;
    e_core = !c_hard && cnt_hard >= 2;
    e_soft = !c_soft && cnt_soft >= 2;
    e_done = !c_hard && samp;
    eb     = c_hard ? 3'd0 : m_boot;
    chk("R1 test_rst_n", 64'(test_rst_n), 64'(e_test));
    chk("R2 core_rst_n", 64'(core_rst_n), 64'(e_core));
    chk("R3 soft_rst_n", 64'(soft_rst_n), 64'(e_soft));
    chk("R5 R6 boot_mode", 64'(boot_mode), 64'(eb));
    chk("R5 R6 mem_cfg", 64'(mem_cfg), 64'(c_hard ? 3'd0 : m_cfg));
    chk("R5 R6 osc_mode", 64'(osc_mode), 64'(c_hard ? 1'b0 : m_osc));
    chk("R7 strap_done", 64'(strap_done), 64'(e_done));
    chk("R8 rom_boot", 64'(rom_boot), 64'(eb != 3'd1));
    chk("R9 always-on enables", 64'(mod_en_dflt & AON), 64'(AON));
    chk("R10 mode enables", 64'(mod_en_dflt), 64'(exp_en(eb)));
    chk("R4 mod_rst_n", 64'(mod_rst_n), 64'(e_core ? m_mod : '0));
    // advance model to the next rising edge
    cnt_por  = c_por  ? 0 : (cnt_por  < 2 ? cnt_por  + 1 : 2);
    cnt_hard = c_hard ? 0 : (cnt_hard < 2 ? cnt_hard + 1 : 2);
    cnt_soft = c_soft ? 0 : (cnt_soft < 2 ? cnt_soft + 1 : 2);
    if (c_hard) begin
      samp = 0; m_boot = 0; m_cfg = 0; m_osc = 0;
    end else if (!samp) begin
      samp = 1; m_boot = strap_bus[13:11]; m_cfg = strap_bus[10:8]; m_osc = osc_strap;
    end
    m_mod = e_core ? ~mod_rst_bits : '0;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] pins(input bit [2:0] m, input bit [2:0] c, input bit [7:0] fill);
    return {2'b10, m, c, fill};
  endfunction

  initial begin
    ext_rst_n = 0; tst_rst_n = 0; max_rst_req = 0; sys_rst_req = 0;
    mod_rst_bits = '0; strap_bus = pins(3'd3, 3'd5, 8'hA5); osc_strap = 1;
    step(4);
    // R1 R5: power-on release captures UART mode
    ext_rst_n = 1; tst_rst_n = 1;
    step(6);
    // R6: pins return to bus traffic
    strap_bus = 16'hFFFF; osc_strap = 0;
    step(4);
    strap_bus = 16'h1234;
    // R4: per-module resets
    mod_rst_bits = (52'd1 << 19) | 52'd1;
    step(3);
    mod_rst_bits = '1;
    step(2);
    mod_rst_bits = 52'h5_5555_0000_AAAA;
    step(2);
    // R3: soft reset, straps not re-sampled
    strap_bus = pins(3'd1, 3'd0, 8'h00);
    sys_rst_req = 1;
    step(3);
    sys_rst_req = 0;
    step(5);
    // R2: max reset with external-memory straps
    strap_bus = pins(3'd1, 3'd2, 8'h3C); osc_strap = 1;
    max_rst_req = 1;
    step(3);
    max_rst_req = 0;
    step(2);
    strap_bus = 16'h0000;
    step(4);
    mod_rst_bits = '0;
    // R2 R8 R9 R10: warm reset through every boot mode
    for (int m = 0; m < 8; m++) begin
      strap_bus = pins(3'(m), 3'(7 - m), 8'(m * 17));
      osc_strap = m[0];
      ext_rst_n = 0;
      step(2);
      ext_rst_n = 1;
      step(3);
      strap_bus = ~strap_bus;
      mod_rst_bits = 52'd1 << (m * 6);
      step(3);
    end
    // R1: test pin released before reset pin
    strap_bus = pins(3'd0, 3'd0, 8'h00); osc_strap = 0;
    ext_rst_n = 0; tst_rst_n = 0;
    step(3);
    tst_rst_n = 1;
    step(3);
    ext_rst_n = 1;
    step(6);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule